// File: doc/BRIEF.md
# I2C Two-Stage Clock Generator

This block derives the two timing references an I2C controller needs from its system clock. A power-of-two prescaler produces a one-cycle bus-sampling strobe. A second divider counts those strobes to produce a free-running SCL phase for master mode, with a 50% duty cycle. One-cycle strobes mark each SCL rising and falling edge, so the master shift logic can act on them.

Both dividers are set from a single write-only 8-bit control register on a simple register bus. The register holds the exponent N and the scalar M. The SCL rate is derived from the sampling rate, not directly from the system clock. This allows the sampling rate to stay well above the fastest SCL on the bus while the local SCL runs slower. Any write to the register restarts both dividers, and SCL restarts in its high phase.

Top module: `i2c_clk_gen`

## Requirements
- R1: After reset the control register holds 0 (M=0, N=0). `scl_o` is high, `scl_rise_o` and `scl_fall_o` are low, and `samp_o` is high on every cycle. With `scl_en_i` high, the SCL period is then 10 cycles.
- R2: A write with `bus_wr_i` high and `bus_addr_i` equal to `CCR_ADDR` loads the register. M is taken from data bits [6:3] and N from bits [2:0]. Bit 7 is reserved and has no effect on any output.
- R3: `samp_o` is a one-cycle pulse that repeats every 2^N cycles, and is high on every cycle when N=0. After a register write, the first pulse falls in the 2^N-th cycle, counting the cycle just after the write edge as the first.
- R4: With `scl_en_i` high, the SCL period is 10·(M+1)·2^N system cycles. SCL is high for 5·(M+1)·2^N cycles and low for the same number of cycles.
- R5: `scl_rise_o` is high exactly in the first cycle of each SCL high phase produced by the divider. `scl_fall_o` is high exactly in the first cycle of each low phase. The two strobes are never high together.
- R6: A register write clears both divider counters, drives `scl_o` high in the next cycle, and suppresses both edge strobes in that cycle. `scl_o` then stays high for exactly 5·(M+1)·2^N cycles, counted from the cycle after the write edge.
- R7: While `scl_en_i` is low, `scl_o` is high from the next cycle on and no edge strobe is emitted. `samp_o` keeps pulsing every 2^N cycles during this time.
- R8: A read at `CCR_ADDR` (`bus_rd_i` high) returns `stat_i` on `bus_rdata_o` and never the register contents. At any other address, and when no read is active, `bus_rdata_o` is 0.
- R9: A write to any address other than `CCR_ADDR` changes neither the register nor the SCL or sample timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_wr_i | input | 1 | Register bus write enable |
| bus_rd_i | input | 1 | Register bus read enable |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data |
| stat_i | input | 8 | Read-only status byte that shares the control address |
| scl_en_i | input | 1 | Enables the SCL divider |
| samp_o | output | 1 | Bus-sampling strobe |
| scl_o | output | 1 | SCL phase (1 = high) |
| scl_rise_o | output | 1 | Strobe in the first cycle of SCL high |
| scl_fall_o | output | 1 | Strobe in the first cycle of SCL low |

## Verification
The bench measures several cases against a behavioural model:
- **Write restart:** the SCL high time right after a write. A design that failed to clear the divider on a write would show a shortened first phase.
- **Prescaler corner cases:** N=0, where a design that tests the counter the wrong way would stop strobing, and N=7, where the limit must not overflow the counter.
- **Extreme period:** M=15 with N=7, the longest period.
- **Reserved bit:** bit 7 is set in one write. A design that decoded it as part of M would produce a wrong period.
- **Address decode:** a write to a neighbouring address must not retime SCL.
- **Read path:** a read at the control address must return the status byte, not the register contents.
- **Disable:** SCL must hold high with no strobes while the sample strobe keeps counting.

// File: rtl/i2c_clkgen_pkg.sv
package i2c_clkgen_pkg;
  localparam int M_W    = 4;
  localparam int N_W    = 3;
  localparam int PCNT_W = (1 << N_W) - 1;          // holds 2^Nmax - 1
  localparam int SCNT_W = $clog2(5 * (1 << M_W));  // holds 5*(Mmax+1) - 1

  typedef struct packed {
    logic           rsvd;
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } ccr_t;
endpackage

// File: rtl/i2c_ccr_reg.sv
module i2c_ccr_reg
  import i2c_clkgen_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CCR_ADDR = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic [7:0]        stat_i,
  output logic [7:0]        bus_rdata_o,
  output ccr_t              ccr_o,
  output logic              restart_o
);
  logic hit, wr_hit;
  ccr_t ccr_q;

  assign hit       = (bus_addr_i == CCR_ADDR);
  assign wr_hit    = hit & bus_wr_i;
  assign restart_o = wr_hit;
  // write-only: the shared address reads back status
  assign bus_rdata_o = (bus_rd_i && hit) ? stat_i : '0;
  assign ccr_o       = ccr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ccr_q <= '0;
    else if (wr_hit) ccr_q <= ccr_t'({1'b0, bus_wdata_i[6:0]});
  end
endmodule

// File: rtl/i2c_samp_prescaler.sv
module i2c_samp_prescaler
  import i2c_clkgen_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic [N_W-1:0] n_i,
  output logic           samp_o
);
  logic [PCNT_W-1:0] cnt_q, lim;
  logic [PCNT_W:0]   pow;

  assign pow    = {{PCNT_W{1'b0}}, 1'b1} << n_i;
  assign lim    = PCNT_W'(pow - 1'b1);
  assign samp_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || samp_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
  import i2c_clkgen_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           en_i,
  input  logic           samp_i,
  input  logic [M_W-1:0] m_i,
  output logic           scl_o,
  output logic           rise_o,
  output logic           fall_o
);
  logic [SCNT_W-1:0] cnt_q, half_m1;
  logic              scl_q, rise_q, fall_q, last, toggle;

  // half period minus one in strobes: 5*(M+1)-1
  assign half_m1 = SCNT_W'({m_i, 2'b00}) + SCNT_W'(m_i) + SCNT_W'(4);
  assign last    = (cnt_q == half_m1);
  assign toggle  = en_i & samp_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      scl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (restart_i || !en_i) begin
      cnt_q  <= '0;
      scl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= toggle & ~scl_q;
      fall_q <= toggle & scl_q;
      if (samp_i) begin
        if (last) begin
          cnt_q <= '0;
          scl_q <= ~scl_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign scl_o  = scl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/i2c_clk_gen.sv
module i2c_clk_gen
  import i2c_clkgen_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CCR_ADDR = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [7:0]        stat_i,
  input  logic              scl_en_i,
  output logic              samp_o,
  output logic              scl_o,
  output logic              scl_rise_o,
  output logic              scl_fall_o
);
  ccr_t           ccr;
  logic           restart;
  logic [N_W-1:0] n_cur;

  assign n_cur = ccr.n;

  i2c_ccr_reg #(.ADDR_W(ADDR_W), .CCR_ADDR(CCR_ADDR)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wdata_i (bus_wdata_i),
    .stat_i      (stat_i),
    .bus_rdata_o (bus_rdata_o),
    .ccr_o       (ccr),
    .restart_o   (restart)
  );

  i2c_samp_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .n_i       (ccr.n),
    .samp_o    (samp_o)
  );

  i2c_scl_divider u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .en_i      (scl_en_i),
    .samp_i    (samp_o),
    .m_i       (ccr.m),
    .scl_o     (scl_o),
    .rise_o    (scl_rise_o),
    .fall_o    (scl_fall_o)
  );
endmodule

// File: rtl/i2c_clk_gen_chk.sv
module i2c_clk_gen_chk
  import i2c_clkgen_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CCR_ADDR = 8'h30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [7:0]        stat_i,
  input logic [7:0]        bus_rdata_o,
  input logic              scl_en_i,
  input logic              samp_o,
  input logic              scl_o,
  input logic              scl_rise_o,
  input logic              scl_fall_o,
  input logic [N_W-1:0]    n_cur
);
  logic hit;
  assign hit = (bus_addr_i == CCR_ADDR);

  AST_N0_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_cur == '0) |-> samp_o); // R3
  AST_RISE_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> (scl_o && !$past(scl_o))); // R5
  AST_FALL_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> (!scl_o && $past(scl_o))); // R5
  AST_FELL_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> scl_fall_o); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_rise_o && scl_fall_o)); // R5
  AST_WR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hit) |=> (scl_o && !scl_rise_o && !scl_fall_o)); // R6
  AST_DIS_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_en_i |=> (scl_o && !scl_rise_o && !scl_fall_o)); // R7
  AST_RD_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && hit) |-> (bus_rdata_o == stat_i)); // R8
  AST_RD_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_i && hit) |-> (bus_rdata_o == 8'h00)); // R8
endmodule

bind i2c_clk_gen i2c_clk_gen_chk #(.ADDR_W(ADDR_W), .CCR_ADDR(CCR_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .stat_i      (stat_i),
  .bus_rdata_o (bus_rdata_o),
  .scl_en_i    (scl_en_i),
  .samp_o      (samp_o),
  .scl_o       (scl_o),
  .scl_rise_o  (scl_rise_o),
  .scl_fall_o  (scl_fall_o),
  .n_cur       (n_cur)
);

// File: tb/sim_i2c_clk_gen.sv
`timescale 1ns/1ps
module sim_i2c_clk_gen;
  localparam logic [7:0] CCR = 8'h30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, stat = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, en = 1'b0;
  logic [7:0] rdata;
  logic       samp, scl, rise, fall;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_clk_gen #(.ADDR_W(8), .CCR_ADDR(CCR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
    .stat_i(stat), .scl_en_i(en), .samp_o(samp), .scl_o(scl),
    .scl_rise_o(rise), .scl_fall_o(fall)
  );

  // behavioural reference model
  int m_m = 0, m_n = 0, pc = 0, sc = 0;
  bit m_scl = 1, m_rise = 0, m_fall = 0;
  bit s_e, tog;
  int hm1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_m = 0; m_n = 0; pc = 0; sc = 0; m_scl = 1; m_rise = 0; m_fall = 0;
    end else begin
      s_e = (pc == (1 << m_n) - 1);
      hm1 = 5 * (m_m + 1) - 1;
      tog = en && s_e && (sc == hm1);
      if (bus_wr && bus_addr == CCR) begin
        m_m = (bus_wdata >> 3) & 15; m_n = bus_wdata & 7;
        pc = 0; sc = 0; m_scl = 1; m_rise = 0; m_fall = 0;
      end else begin
        pc = s_e ? 0 : pc + 1;
        if (!en) begin
          sc = 0; m_scl = 1; m_rise = 0; m_fall = 0;
        end else begin
          m_rise = tog && !m_scl;
          m_fall = tog && m_scl;
          if (s_e) begin
            if (sc == hm1) begin sc = 0; m_scl = !m_scl; end
            else sc++;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (!done) begin
    chk(samp == (pc == (1 << m_n) - 1), "R3 samp", samp, pc == (1 << m_n) - 1);
    chk(scl == m_scl, "R4 scl", scl, m_scl);
    chk(rise == m_rise, "R5 rise", rise, m_rise);
    chk(fall == m_fall, "R5 fall", fall, m_fall);
    chk(rdata == ((bus_rd && bus_addr == CCR) ? stat : 8'h00), "R8 rdata",
        rdata, (bus_rd && bus_addr == CCR) ? stat : 0);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic fall_period(output int n);
    while (!fall) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!fall);
  endtask

  task automatic high_time(output int n);
    while (!rise) @(negedge clk);
    n = 0;
    while (scl) begin n++; @(negedge clk); end
  endtask

  task automatic high_after_wr(output int n);
    n = 0;
    while (scl) begin n++; @(negedge clk); end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      summary(); $finish;
    end
  end

  initial begin
    int n, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; en = 1'b1;
    // R1: reset state
    chk(scl == 1, "R1 scl_o", scl, 1);
    chk(samp == 1, "R1 samp_o", samp, 1);
    chk(!rise && !fall, "R1 strobes", rise | fall, 0);
    @(negedge clk);
    chk(samp == 1, "R1 samp every cycle", samp, 1);
    fall_period(n); chk(n == 10, "R1 period", n, 10);

    // R2: reserved bit 7 set, M=2 N=1
    wr(CCR, 8'h91);
    high_after_wr(n); chk(n == 30, "R6 high after write", n, 30);
    fall_period(n); chk(n == 60, "R2 R4 period M2N1", n, 60);
    high_time(n); chk(n == 30, "R4 high half", n, 30);
    while (!samp) @(negedge clk);
    n = 0; do begin @(negedge clk); n++; end while (!samp);
    chk(n == 2, "R3 samp spacing", n, 2);

    // M=1 N=3
    wr(CCR, 8'h0B);
    n = 1; while (!samp) begin n++; @(negedge clk); end
    chk(n == 8, "R3 first strobe", n, 8);
    fall_period(n); chk(n == 160, "R4 period M1N3", n, 160);

    // R9: write elsewhere ignored
    wr(8'h31, 8'h00);
    fall_period(n); chk(n == 160, "R9 period unchanged", n, 160);

    // R8: read path
    @(negedge clk); stat = 8'hA5; bus_rd = 1'b1; bus_addr = CCR; #1;
    chk(rdata == 8'hA5, "R8 status read", rdata, 8'hA5);
    bus_addr = 8'h31; #1;
    chk(rdata == 8'h00, "R8 miss read", rdata, 0);
    @(negedge clk); bus_rd = 1'b0; bus_addr = '0;

    // R7: disable holds SCL high, sample strobe runs
    en = 1'b0; @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      chk(scl && !rise && !fall, "R7 disabled scl", scl, 1);
      if (samp) cnt++;
      @(negedge clk);
    end
    chk(cnt == 5, "R7 samp runs", cnt, 5);
    en = 1'b1;

    // extreme M=15 N=7
    wr(CCR, 8'h7F);
    high_after_wr(n); chk(n == 10240, "R6 high after write max", n, 10240);
    fall_period(n); chk(n == 20480, "R4 period max", n, 20480);

    done = 1;
    summary();
    $finish;
  end
endmodule